// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Selectable Bit Order

This block receives asynchronous serial frames on a single input line and turns each into a parallel byte. A prescaled tick generator sets the oversampling rate. Each bit lasts sixteen ticks. The count source for the tick generator is either the system clock or the system clock divided by eight. An 8-bit divisor then divides that source by (divisor + 1).

A frame is made of these parts, in this order:
- a low start bit,
- eight data bits,
- a parity bit, which is present only when parity is enabled,
- a high stop bit.

The bit-order input decides where the first data bit lands in the byte: at bit 0 (lowest first) or at bit 7 (highest first). The line can be logically inverted before any processing. This serves links whose idle level is low.

For each completed frame, the block outputs the byte, a parity-error flag and a framing-error flag, together with a one-cycle valid strobe. These outputs stay unchanged until the next frame completes.

Top module: `uart_rx_order`

## Requirements
- R1: The oversampling tick occurs once every (cfg_divisor + 1) count-source cycles. The count source is every clock when cfg_slow_src = 0, and every eighth clock when cfg_slow_src = 1. One bit period is 16 ticks.
- R2: A high-to-low transition of the conditioned line starts a frame. The line must still be low at the 8th tick of the start bit. If the line is high at that point, the receiver returns to idle without a valid strobe and without changing any output.
- R3: Data, parity and stop bits are each sampled at the 8th tick of their bit period. The frame is start, 8 data bits, a parity bit only when cfg_par_en = 1, then stop.
- R4: With cfg_msb_first = 0, the first data bit received is stored in rx_data[0] and the last in rx_data[7].
- R5: With cfg_msb_first = 1, the first data bit received is stored in rx_data[7] and the last in rx_data[0].
- R6: rx_par_err is set when parity is enabled and the parity bit disagrees with the data. cfg_par_odd = 0 selects even parity: the data plus the parity bit hold an even number of ones. cfg_par_odd = 1 selects odd parity. With cfg_par_en = 0, rx_par_err is always 0.
- R7: rx_frm_err is set when the sampled stop bit is low, and cleared when it is high.
- R8: With cfg_invert = 1, the rxd input is complemented before all other processing, so the idle level is low. With cfg_invert = 0, rxd is used as is.
- R9: rx_valid is high for exactly one clock, at the 16th tick of the stop bit. rx_data, rx_par_err and rx_frm_err update in that same cycle and hold until the next valid.
- R10: The synchronous active-high rst clears rx_data, rx_valid, rx_par_err and rx_frm_err and forces the receiver to idle, even in the middle of a frame.
- R11: A start edge that arrives after the stop bit has been sampled, but before its 16th tick, completes the current frame at once and begins a new one, so frames sent back to back are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slow_src | input | 1 | Count source select: 0 = clock, 1 = clock/8 |
| cfg_divisor | input | DIV_W | Tick divisor n; tick rate = source/(n+1) |
| cfg_msb_first | input | 1 | Bit order: 0 = first bit to bit 0, 1 = first bit to bit 7 |
| cfg_par_en | input | 1 | Parity bit present in frame |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_invert | input | 1 | Complement the serial input |
| rxd | input | 1 | Serial data line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| rx_par_err | output | 1 | Parity mismatch on the last frame |
| rx_frm_err | output | 1 | Low stop bit on the last frame |

## Verification
The hardest situation to create from the ports is a start that is rejected. The line must fall and then rise again before the 8th tick, without disturbing the bytes already held. The bench drives a low glitch a few ticks long after a good frame. It then checks that no strobe appears and that the earlier byte and flags are still present. Bit order is tested by sending frames in the order opposite to the configured one and expecting the bit-reversed byte. Back-to-back frames with no idle gap exercise the early completion of the stop bit.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    localparam int DATA_W    = 8;
    localparam int OSR       = 16;
    localparam int SAMPLE_AT = 7;
    localparam int CNT_W     = $clog2(OSR);
    localparam int IDX_W     = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic msb_first;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_result_t;

    // 1 when data and parity bit together violate the selected parity
    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic p,
                                        input logic odd);
        return (^d) ^ p ^ odd;
    endfunction

    // Slot in the byte that receives data bit number idx
    function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] idx,
                                                 input logic msb_first);
        return msb_first ? (IDX_W'(DATA_W - 1) - idx) : idx;
    endfunction

endpackage

// File: rtl/rxo_tick_gen.sv
module rxo_tick_gen #(
    parameter int DIV_W   = 8,
    parameter int PRE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_src,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             src_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (pre_cnt == PRE_W'(PRE_DIV - 1)) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign src_en = slow_src ? (pre_cnt == PRE_W'(PRE_DIV - 1)) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (src_en) begin
            if (div_cnt == '0) begin
                div_cnt <= divisor;
                tick    <= 1'b1;
            end else begin
                div_cnt <= div_cnt - 1'b1;
                tick    <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rxo_line_cond.sv
module rxo_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    input  logic invert,
    output logic line,
    output logic fall
);
    logic [STAGES-1:0] sr;
    logic              line_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sr[0] <= 1'b1;
                else     sr[0] <= rxd ^ invert;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sr[i] <= 1'b1;
                else     sr[i] <= sr[i-1];
            end
        end
    end

    assign line = sr[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) line_d <= 1'b1;
        else     line_d <= line;
    end

    assign fall = line_d & ~line;
endmodule

// File: rtl/rxo_frame.sv
module rxo_frame
    import rxo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             line,
    input  logic             fall,
    input  frame_cfg_t       cfg,
    output logic             valid,
    output rx_result_t       result,
    output rx_state_e        state_o,
    output logic [CNT_W-1:0] tcnt_o
);
    rx_state_e         state;
    logic [CNT_W-1:0]  tcnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              sbit;
    logic              stop_done;
    logic              sample;
    logic              bit_end;
    logic              restart;
    logic              finish;
    logic              data_sample;
    logic [IDX_W-1:0]  slot;

    assign sample      = tick && (tcnt == CNT_W'(SAMPLE_AT));
    assign bit_end     = tick && (tcnt == CNT_W'(OSR - 1));
    assign restart     = fall && ((state == ST_IDLE) || (state == ST_STOP && stop_done));
    assign finish      = (state == ST_STOP) && (bit_end || (stop_done && fall));
    assign data_sample = (state == ST_DATA) && sample;
    assign slot        = slot_of(idx, cfg.msb_first);

    // Tick counter within the current bit
    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if (restart) begin
            tcnt <= '0;
        end else if (state != ST_IDLE && tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Byte assembly: each slot loads from the line when it is addressed
    for (genvar b = 0; b < DATA_W; b++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                shreg[b] <= 1'b0;
            end else if (data_sample && slot == IDX_W'(b)) begin
                shreg[b] <= line;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= '0;
            pbit      <= 1'b0;
            sbit      <= 1'b1;
            stop_done <= 1'b0;
            valid     <= 1'b0;
            result    <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fall) state <= ST_START;
                end
                ST_START: begin
                    if (sample && line) begin
                        state <= ST_IDLE;
                    end else if (bit_end) begin
                        state <= ST_DATA;
                        idx   <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if (idx == IDX_W'(DATA_W - 1)) begin
                            state     <= cfg.par_en ? ST_PAR : ST_STOP;
                            stop_done <= 1'b0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (sample) pbit <= line;
                    if (bit_end) begin
                        state     <= ST_STOP;
                        stop_done <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (sample) begin
                        sbit      <= line;
                        stop_done <= 1'b1;
                    end
                    if (finish) begin
                        valid          <= 1'b1;
                        result.data    <= shreg;
                        result.par_err <= cfg.par_en & parity_bad(shreg, pbit, cfg.par_odd);
                        result.frm_err <= ~sbit;
                        stop_done      <= 1'b0;
                        state          <= fall ? ST_START : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state;
    assign tcnt_o  = tcnt;
endmodule

// File: rtl/uart_rx_order.sv
module uart_rx_order
    import rxo_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int PRE_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_slow_src,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic              cfg_msb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_invert,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err
);
    logic             tick_w;
    logic             line_w;
    logic             fall_w;
    frame_cfg_t       fcfg;
    rx_result_t       res;
    rx_state_e        st_w;
    logic [CNT_W-1:0] tcnt_w;

    assign fcfg = '{msb_first: cfg_msb_first, par_en: cfg_par_en, par_odd: cfg_par_odd};

    rxo_tick_gen #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .slow_src (cfg_slow_src),
        .divisor  (cfg_divisor),
        .tick     (tick_w)
    );

    rxo_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst    (rst),
        .rxd    (rxd),
        .invert (cfg_invert),
        .line   (line_w),
        .fall   (fall_w)
    );

    rxo_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .line    (line_w),
        .fall    (fall_w),
        .cfg     (fcfg),
        .valid   (rx_valid),
        .result  (res),
        .state_o (st_w),
        .tcnt_o  (tcnt_w)
    );

    assign rx_data    = res.data;
    assign rx_par_err = res.par_err;
    assign rx_frm_err = res.frm_err;
endmodule

// File: rtl/rxo_checker.sv
module rxo_checker
    import rxo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_slow_src,
    input logic              cfg_par_en,
    input logic              tick,
    input logic              line,
    input rx_state_e         state,
    input logic [CNT_W-1:0]  tcnt,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_par_err,
    input logic              rx_frm_err
);
    // R9: the strobe lasts a single clock
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9: results only move together with the strobe
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_par_err) && $stable(rx_frm_err)));

    // R6: no parity error reported while parity is off
    assert_no_par_err_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_par_en) |-> !rx_par_err);

    // R2: a high line at the start-bit sample point abandons the frame
    assert_false_start_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && tcnt == CNT_W'(SAMPLE_AT) && line) |=> (state == ST_IDLE));

    // R1: with the slow source, ticks are never adjacent
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg_slow_src) |=> !tick);
endmodule

bind uart_rx_order rxo_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_slow_src (cfg_slow_src),
    .cfg_par_en   (cfg_par_en),
    .tick         (tick_w),
    .line         (line_w),
    .state        (st_w),
    .tcnt         (tcnt_w),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_par_err   (rx_par_err),
    .rx_frm_err   (rx_frm_err)
);

// File: tb/sim_uart_rx_order.sv
module sim_uart_rx_order;
    localparam int CLK_P    = 10;
    localparam int WDOG_MAX = 150000;

    typedef struct packed {
        logic [7:0] data;
        logic       msb;
        logic       pen;
        logic       odd;
        logic       inv;
        logic       s8;
        logic [7:0] div;
        logic       rev;
        logic       pbad;
        logic       sbad;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0},
        '{8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0},
        '{8'hC3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0},
        '{8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b0},
        '{8'h7E, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b0},
        '{8'h33, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1},
        '{8'h96, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0},
        '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1, 1'b0},
        '{8'hF0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0},
        '{8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_slow_src = 1'b0;
    logic [7:0] cfg_divisor = 8'd0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_par_en = 1'b1;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_par_err;
    logic       rx_frm_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cap_n = 0;
    int cap_cyc = 0;
    int wide = 0;
    int stop_begin = 0;
    logic [7:0] cap_d = 8'h00;
    logic [7:0] cap_prev = 8'h00;
    logic       cap_pe = 1'b0;
    logic       cap_fe = 1'b0;
    logic       prev_v = 1'b0;

    uart_rx_order u0 (
        .clk           (clk),
        .rst           (rst),
        .cfg_slow_src  (cfg_slow_src),
        .cfg_divisor   (cfg_divisor),
        .cfg_msb_first (cfg_msb_first),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .cfg_invert    (cfg_invert),
        .rxd           (rxd),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_par_err    (rx_par_err),
        .rx_frm_err    (rx_frm_err)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_n    <= cap_n + 1;
            cap_prev <= cap_d;
            cap_d    <= rx_data;
            cap_pe   <= rx_par_err;
            cap_fe   <= rx_frm_err;
            cap_cyc  <= cyc;
        end
        if (rx_valid && prev_v) wide <= wide + 1;
        prev_v <= rx_valid;
    end

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WDOG_MAX) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run hung got %0d exp %0d", cyc, WDOG_MAX);
            summary_and_end();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s got %0h exp %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    task automatic put_bit(input logic b, input int n);
        rxd = b ^ cfg_invert;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic first_hi,
                              input logic pbad, input logic sbad, input int bclk);
        put_bit(1'b0, bclk);
        for (int i = 0; i < 8; i++) put_bit(first_hi ? d[7-i] : d[i], bclk);
        if (cfg_par_en) put_bit((^d) ^ cfg_par_odd ^ pbad, bclk);
        stop_begin = cyc;
        put_bit(~sbad, bclk);
    endtask

    initial begin
        int bclk;
        int n0;
        logic [7:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state at the ports
        check("R10 reset data", rx_data, 0);
        check("R10 reset valid", rx_valid, 0);
        check("R10 reset flags", {rx_par_err, rx_frm_err}, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            cfg_slow_src  = VEC[v].s8;
            cfg_divisor   = VEC[v].div;
            cfg_msb_first = VEC[v].msb;
            cfg_par_en    = VEC[v].pen;
            cfg_par_odd   = VEC[v].odd;
            cfg_invert    = VEC[v].inv;
            rxd           = 1'b1 ^ VEC[v].inv;
            bclk = 16 * (int'(VEC[v].div) + 1) * (VEC[v].s8 ? 8 : 1);
            repeat (2 * bclk) @(negedge clk);
            n0 = cap_n;
            send_frame(VEC[v].data, VEC[v].msb ^ VEC[v].rev, VEC[v].pbad, VEC[v].sbad, bclk);
            put_bit(1'b1, 2 * bclk);
            check("R3 one frame received", cap_n - n0, 1);
            // R4 R5 R8: byte placed by bit order, inverted line decoded
            check(VEC[v].msb ? "R5 data" : "R4 data", cap_d,
                  VEC[v].rev ? rev8(VEC[v].data) : VEC[v].data);
            check("R6 parity flag", cap_pe, VEC[v].pen & VEC[v].pbad);
            check("R7 framing flag", cap_fe, VEC[v].sbad);
            // R1 R9: strobe near the end of the stop bit at this baud rate
            check("R1 R9 strobe timing",
                  (cap_cyc > stop_begin + bclk / 2) && (cap_cyc <= stop_begin + bclk + 4), 1);
        end

        // Directed: false start (R2)
        cfg_slow_src = 1'b0; cfg_divisor = 8'd0; cfg_msb_first = 1'b0;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_invert = 1'b0; rxd = 1'b1;
        bclk = 16;
        repeat (40) @(negedge clk);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0, bclk);
        put_bit(1'b1, 2 * bclk);
        held = rx_data;
        n0 = cap_n;
        put_bit(1'b0, 4);
        put_bit(1'b1, 4 * bclk);
        check("R2 false start no strobe", cap_n - n0, 0);
        check("R2 false start data held", rx_data, held);
        check("R9 flags held", {rx_par_err, rx_frm_err}, 0);

        // Directed: back to back frames (R11)
        n0 = cap_n;
        send_frame(8'hA1, 1'b0, 1'b0, 1'b0, bclk);
        send_frame(8'h4B, 1'b0, 1'b0, 1'b0, bclk);
        put_bit(1'b1, 2 * bclk);
        check("R11 two frames", cap_n - n0, 2);
        check("R11 first byte", cap_prev, 8'hA1);
        check("R11 second byte", cap_d, 8'h4B);

        // Directed: reset mid-frame (R10)
        put_bit(1'b0, bclk);
        put_bit(1'b1, bclk);
        put_bit(1'b0, bclk / 2);
        rst = 1'b1;
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        n0 = cap_n;
        repeat (3 * bclk) @(negedge clk);
        check("R10 mid-frame reset data", rx_data, 0);
        check("R10 mid-frame reset no strobe", cap_n - n0, 0);
        send_frame(8'hE7, 1'b0, 1'b0, 1'b0, bclk);
        put_bit(1'b1, 2 * bclk);
        check("R10 receive after reset", cap_d, 8'hE7);

        // R9: every strobe was one clock wide
        check("R9 strobe width", wide, 0);

        summary_and_end();
    end
endmodule